// File: doc/BRIEF.md
# Video Controller Control Register Bank

This block is the control register bank of a video and render controller. It sits on a simple 32-bit bus that carries a word address, a write strobe and write data, and it returns read data in the same cycle from the address on the bus. Each configuration register keeps only its implemented bits. Unimplemented bits always read back as zero.

A few addresses behave differently. The identity, version and position registers are read-only. Four reserved offsets swallow writes. Three locations act as commands instead of storing data:
- a render-go register that fires only on one exact value,
- a tile-engine reset register that fires on its top bit,
- the primary display-address register, which stores its value and also raises a frame trigger.

A 1 KiB lookup table inside the bank is written without masking. Every other in-bank address is plain 32-bit storage. Register offsets are set through a map parameter, so the bank can be placed to match the consumers that decode it.

Top module: `vrc_regbank`

## Requirements
- R1: A write anywhere in the table window, byte offsets 0x200 to 0x5FF, stores all 32 bits unmasked, and the stored word reads back.
- R2: Writes to the identity (0x000), version (0x004), light-gun position (0x0C4), tile-engine polygon position (0x138) and tile-engine list position (0x134) registers are ignored. Identity reads ID_VALUE (default 0x0C0DE101), version reads VER_VALUE (default 0x00000011), and the other three read 0.
- R3: Writes to the reserved offsets 0x01C, 0x024, 0x028 and 0x058 are discarded, and these offsets always read 0.
- R4: A write of exactly 0xFFFFFFFF to the render-go offset (0x014) drives render_start_o high for exactly the one cycle after the write edge. Any other value gives no pulse. The register reads 0.
- R5: A write to the tile-engine reset offset (0x144) with bit 31 set drives ta_init_o high for the one cycle after the write edge. With bit 31 clear there is no pulse. The register reads 0.
- R6: Every write to the primary display address (0x050) drives frame_trig_o high for the one cycle after the write edge. A write to the secondary display address (0x054) does not.
- R7: The display address registers (0x050, 0x054) store wdata & 0x00FFFFFC. The render address registers (0x060, 0x064) store wdata & 0x01FFFFFC.
- R8: The border colour (0x040) stores wdata & 0x01FFFFFF, the display mode (0x044) stores wdata & 0x00FFFF7F, and the display size (0x05C) stores wdata & 0x3FFFFFFF.
- R9: The horizontal clip (0x068) stores wdata & 0x07FF07FF, the vertical clip (0x06C) stores wdata & 0x03FF03FF, and the horizontal interrupt position (0x0C8) stores wdata & 0x03FF33FF.
- R10: The tile base (0x124), list base (0x128) and list end (0x130) store wdata & 0x00FFFFE0. The tile size (0x13C) stores wdata & 0x000F003F, and the tile configuration (0x140) stores wdata & 0x00133333.
- R11: Any other offset below 0x600 stores the full 32-bit value. Offsets 0x600 and above ignore writes and read 0.
- R12: bus_rdata shows the stored word for bus_addr in the same cycle, and address bits 1:0 are ignored. After reset, all storage and all three pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (11) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| render_start_o | output | 1 | One-cycle render-go command pulse |
| ta_init_o | output | 1 | One-cycle tile-engine reset command pulse |
| frame_trig_o | output | 1 | One-cycle frame trigger on a primary display address write |

## Verification
The bench writes all-ones and then an alternating pattern into every masked register. A swapped or mistyped mask would leave a stray bit set, such as bit 7 of the display mode or bit 1 of a display address. It writes 0xFFFFFFFE and 0x7FFFFFFF to the command offsets, where a decoder that tests only a few bits would fire falsely. It writes 0xFFFFFFFF and 0x80000000 to check that the true triggers still fire and that their registers read 0. It also probes the last table word at 0x5FC against the first out-of-bank word at 0x600, the reserved offsets, and the read-only registers, where a design that stored those writes would read them back.

// File: rtl/vrc_regbank_pkg.sv
package vrc_regbank_pkg;

    localparam int DATA_W = 32;

    // Implemented-bit masks per register family
    localparam logic [31:0] MASK_DISP_ADDR = 32'h00FF_FFFC;
    localparam logic [31:0] MASK_RND_ADDR  = 32'h01FF_FFFC;
    localparam logic [31:0] MASK_DSIZE     = 32'h3FFF_FFFF;
    localparam logic [31:0] MASK_DMODE     = 32'h00FF_FF7F;
    localparam logic [31:0] MASK_BORDER    = 32'h01FF_FFFF;
    localparam logic [31:0] MASK_HCLIP     = 32'h07FF_07FF;
    localparam logic [31:0] MASK_VCLIP     = 32'h03FF_03FF;
    localparam logic [31:0] MASK_HIRQ      = 32'h03FF_33FF;
    localparam logic [31:0] MASK_TILE_PTR  = 32'h00FF_FFE0;
    localparam logic [31:0] MASK_TILE_CFG  = 32'h0013_3333;
    localparam logic [31:0] MASK_TILE_SIZE = 32'h000F_003F;

    // Byte offsets of every decoded register
    typedef struct packed {
        logic [15:0] id;
        logic [15:0] ver;
        logic [15:0] gun_pos;
        logic [15:0] ta_poly_pos;
        logic [15:0] ta_list_pos;
        logic [15:0] render_go;
        logic [15:0] ta_reset;
        logic [15:0] disp_addr0;
        logic [15:0] disp_addr1;
        logic [15:0] rnd_addr0;
        logic [15:0] rnd_addr1;
        logic [15:0] disp_size;
        logic [15:0] disp_mode;
        logic [15:0] border;
        logic [15:0] hclip;
        logic [15:0] vclip;
        logic [15:0] hirq;
        logic [15:0] tile_base;
        logic [15:0] list_base;
        logic [15:0] list_end;
        logic [15:0] tile_cfg;
        logic [15:0] tile_size;
        logic [15:0] hole0;
        logic [15:0] hole1;
        logic [15:0] hole2;
        logic [15:0] hole3;
    } reg_map_t;

    localparam reg_map_t DEFAULT_MAP = '{
        id:          16'h000,
        ver:         16'h004,
        gun_pos:     16'h0C4,
        ta_poly_pos: 16'h138,
        ta_list_pos: 16'h134,
        render_go:   16'h014,
        ta_reset:    16'h144,
        disp_addr0:  16'h050,
        disp_addr1:  16'h054,
        rnd_addr0:   16'h060,
        rnd_addr1:   16'h064,
        disp_size:   16'h05C,
        disp_mode:   16'h044,
        border:      16'h040,
        hclip:       16'h068,
        vclip:       16'h06C,
        hirq:        16'h0C8,
        tile_base:   16'h124,
        list_base:   16'h128,
        list_end:    16'h130,
        tile_cfg:    16'h140,
        tile_size:   16'h13C,
        hole0:       16'h01C,
        hole1:       16'h024,
        hole2:       16'h028,
        hole3:       16'h058
    };

    typedef enum logic [2:0] {
        WK_STORE,
        WK_READONLY,
        WK_HOLE,
        WK_RENDER_GO,
        WK_TA_RESET,
        WK_OUTSIDE
    } wr_kind_e;

    typedef enum logic [1:0] {
        RD_MEM,
        RD_ID,
        RD_VER,
        RD_ZERO
    } rd_sel_e;

    typedef struct packed {
        wr_kind_e    kind;
        rd_sel_e     rsel;
        logic [31:0] mask;
        logic        frame;
    } decode_t;

    typedef struct packed {
        logic go;
        logic ta;
        logic frame;
    } cmd_state_t;

endpackage

// File: rtl/vrc_regbank_decode.sv
module vrc_regbank_decode
    import vrc_regbank_pkg::*;
#(
    parameter reg_map_t MAP        = DEFAULT_MAP,
    parameter int       ADDR_W     = 11,
    parameter int       BANK_BYTES = 'h600,
    parameter int       FOG_BASE   = 'h200,
    parameter int       FOG_BYTES  = 'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    localparam logic [15:0] FOG_LO  = 16'(FOG_BASE);
    localparam logic [15:0] FOG_END = 16'(FOG_BASE + FOG_BYTES);
    localparam logic [15:0] BANK_END = 16'(BANK_BYTES);

    logic [15:0] wa;

    always_comb begin
        wa  = 16'(addr) & 16'hFFFC;
        dec = '{kind: WK_STORE, rsel: RD_MEM, mask: '1, frame: 1'b0};

        if (wa >= BANK_END) begin
            dec.kind = WK_OUTSIDE;
            dec.rsel = RD_ZERO;
        end else if (wa >= FOG_LO && wa < FOG_END) begin
            // table window: plain unmasked store
            dec.kind = WK_STORE;
        end else begin
            case (wa)
                MAP.id:          begin dec.kind = WK_READONLY; dec.rsel = RD_ID;  end
                MAP.ver:         begin dec.kind = WK_READONLY; dec.rsel = RD_VER; end
                MAP.gun_pos,
                MAP.ta_poly_pos,
                MAP.ta_list_pos: dec.kind = WK_READONLY;
                MAP.hole0,
                MAP.hole1,
                MAP.hole2,
                MAP.hole3:       dec.kind = WK_HOLE;
                MAP.render_go:   dec.kind = WK_RENDER_GO;
                MAP.ta_reset:    dec.kind = WK_TA_RESET;
                MAP.disp_addr0:  begin dec.mask = MASK_DISP_ADDR; dec.frame = 1'b1; end
                MAP.disp_addr1:  dec.mask = MASK_DISP_ADDR;
                MAP.rnd_addr0,
                MAP.rnd_addr1:   dec.mask = MASK_RND_ADDR;
                MAP.disp_size:   dec.mask = MASK_DSIZE;
                MAP.disp_mode:   dec.mask = MASK_DMODE;
                MAP.border:      dec.mask = MASK_BORDER;
                MAP.hclip:       dec.mask = MASK_HCLIP;
                MAP.vclip:       dec.mask = MASK_VCLIP;
                MAP.hirq:        dec.mask = MASK_HIRQ;
                MAP.tile_base,
                MAP.list_base,
                MAP.list_end:    dec.mask = MASK_TILE_PTR;
                MAP.tile_cfg:    dec.mask = MASK_TILE_CFG;
                MAP.tile_size:   dec.mask = MASK_TILE_SIZE;
                default:         dec.mask = '1;
            endcase
        end
    end

endmodule

// File: rtl/vrc_regbank_store.sv
module vrc_regbank_store #(
    parameter  int NWORDS = 384,
    localparam int IDX_W  = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [31:0]      mask,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);

    logic [31:0] mem_d [NWORDS];
    logic [31:0] mem_q [NWORDS];

    always_comb begin
        mem_d = mem_q;
        if (we && (32'(widx) < NWORDS)) begin
            mem_d[widx] = wdata & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(ridx) < NWORDS) begin
            rdata = mem_q[ridx];
        end
    end

endmodule

// File: rtl/vrc_regbank_cmd.sv
module vrc_regbank_cmd
    import vrc_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  decode_t     dec,
    input  logic [31:0] wdata,
    output logic        render_start,
    output logic        ta_init,
    output logic        frame_trig
);

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.go    = wr && (dec.kind == WK_RENDER_GO) && (wdata == 32'hFFFF_FFFF);
        st_d.ta    = wr && (dec.kind == WK_TA_RESET) && wdata[31];
        st_d.frame = wr && (dec.kind == WK_STORE) && dec.frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign render_start = st_q.go;
    assign ta_init      = st_q.ta;
    assign frame_trig   = st_q.frame;

endmodule

// File: rtl/vrc_regbank.sv
module vrc_regbank
    import vrc_regbank_pkg::*;
#(
    parameter reg_map_t    MAP        = DEFAULT_MAP,
    parameter int          ADDR_W     = 11,
    parameter int          BANK_BYTES = 'h600,
    parameter int          FOG_BASE   = 'h200,
    parameter int          FOG_BYTES  = 'h400,
    parameter logic [31:0] ID_VALUE   = 32'h0C0D_E101,
    parameter logic [31:0] VER_VALUE  = 32'h0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              render_start_o,
    output logic              ta_init_o,
    output logic              frame_trig_o
);

    localparam int NWORDS = BANK_BYTES / 4;
    localparam int IDX_W  = $clog2(NWORDS);

    decode_t          dec;
    logic             store_we;
    logic [IDX_W-1:0] word_idx;
    logic [31:0]      mem_rdata;

    vrc_regbank_decode #(
        .MAP       (MAP),
        .ADDR_W    (ADDR_W),
        .BANK_BYTES(BANK_BYTES),
        .FOG_BASE  (FOG_BASE),
        .FOG_BYTES (FOG_BYTES)
    ) decode_i (
        .addr(bus_addr),
        .dec (dec)
    );

    assign store_we = bus_wr && (dec.kind == WK_STORE);
    assign word_idx = bus_addr[2 +: IDX_W];

    vrc_regbank_store #(
        .NWORDS(NWORDS)
    ) store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (store_we),
        .widx (word_idx),
        .wdata(bus_wdata),
        .mask (dec.mask),
        .ridx (word_idx),
        .rdata(mem_rdata)
    );

    vrc_regbank_cmd cmd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .dec         (dec),
        .wdata       (bus_wdata),
        .render_start(render_start_o),
        .ta_init     (ta_init_o),
        .frame_trig  (frame_trig_o)
    );

    always_comb begin
        case (dec.rsel)
            RD_ID:   bus_rdata = ID_VALUE;
            RD_VER:  bus_rdata = VER_VALUE;
            RD_ZERO: bus_rdata = '0;
            default: bus_rdata = mem_rdata;
        endcase
    end

endmodule

// File: rtl/vrc_regbank_chk.sv
module vrc_regbank_chk
    import vrc_regbank_pkg::*;
#(
    parameter reg_map_t MAP        = DEFAULT_MAP,
    parameter int       ADDR_W     = 11,
    parameter int       BANK_BYTES = 'h600,
    parameter int       FOG_BASE   = 'h200,
    parameter int       FOG_BYTES  = 'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              render_start_o,
    input logic              ta_init_o,
    input logic              frame_trig_o
);

    logic [15:0] wa;
    logic        in_fog;
    assign wa     = 16'(bus_addr) & 16'hFFFC;
    assign in_fog = (wa >= 16'(FOG_BASE)) && (wa < 16'(FOG_BASE + FOG_BYTES));

    // R1: table word reads back exactly what was written
    a_r1_table_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_fog) |=>
        (bus_addr != $past(bus_addr) || bus_rdata == $past(bus_wdata)));

    // R2: a write to the gun position leaves its read value unchanged
    a_r2_gun_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wa == MAP.gun_pos) |=>
        (bus_addr != $past(bus_addr) || $stable(bus_rdata)));

    // R3: reserved offsets read as zero
    a_r3_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wa == MAP.hole0 || wa == MAP.hole1 || wa == MAP.hole2 || wa == MAP.hole3)
        |-> bus_rdata == 32'h0);

    // R4: render-go fires on the exact magic value only
    a_r4_go_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wa == MAP.render_go && bus_wdata == 32'hFFFF_FFFF) |=> render_start_o);
    a_r4_go_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && wa == MAP.render_go && bus_wdata == 32'hFFFF_FFFF) |=> !render_start_o);
    a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({render_start_o, ta_init_o, frame_trig_o}));

    // R5: tile-engine reset follows bit 31
    a_r5_ta_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wa == MAP.ta_reset && bus_wdata[31]) |=> ta_init_o);
    a_r5_ta_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && wa == MAP.ta_reset && bus_wdata[31]) |=> !ta_init_o);

    // R6: frame trigger follows each primary display address write
    a_r6_frame_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wa == MAP.disp_addr0) |=> frame_trig_o);
    a_r6_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && wa == MAP.disp_addr0) |=> !frame_trig_o);

    // R7: primary display address keeps only its implemented bits
    a_r7_disp_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wa == MAP.disp_addr0) |=>
        (bus_addr != $past(bus_addr) || bus_rdata == ($past(bus_wdata) & 32'h00FF_FFFC)));

    // R11: out-of-bank reads are zero
    a_r11_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wa >= 16'(BANK_BYTES)) |-> bus_rdata == 32'h0);

endmodule

bind vrc_regbank vrc_regbank_chk #(
    .MAP       (MAP),
    .ADDR_W    (ADDR_W),
    .BANK_BYTES(BANK_BYTES),
    .FOG_BASE  (FOG_BASE),
    .FOG_BYTES (FOG_BYTES)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .render_start_o(render_start_o),
    .ta_init_o     (ta_init_o),
    .frame_trig_o  (frame_trig_o)
);

// File: tb/vrc_regbank_tb_top.sv
module vrc_regbank_tb_top;

    localparam int          AW     = 11;
    localparam logic [31:0] EXP_ID = 32'h0C0D_E101;
    localparam logic [31:0] EXP_VER = 32'h0000_0011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          render_start_o, ta_init_o, frame_trig_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vrc_regbank dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .render_start_o(render_start_o),
        .ta_init_o     (ta_init_o),
        .frame_trig_o  (frame_trig_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulses(input string req, input logic [2:0] exp);
        check(req, {29'd0, render_start_o, ta_init_o, frame_trig_o}, {29'd0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        pulses("R12 reset pulses", 3'b000);
        rd(11'h000, v); check("R2 reset id", v, EXP_ID);
        rd(11'h004, v); check("R2 reset version", v, EXP_VER);
        rd(11'h050, v); check("R12 reset display address", v, 32'h0);
        rd(11'h3F0, v); check("R12 reset table word", v, 32'h0);
    endtask

    task automatic t_table();
        logic [31:0] v;
        wr(11'h200, 32'hFFFF_FFFF);
        wr(11'h5FC, 32'h1234_5678);
        wr(11'h3A4, 32'hDEAD_BEEF);
        rd(11'h200, v); check("R1 table first word", v, 32'hFFFF_FFFF);
        rd(11'h5FC, v); check("R1 table last word", v, 32'h1234_5678);
        rd(11'h3A4, v); check("R1 table middle word", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_masks();
        logic [AW-1:0] a [15] = '{11'h050, 11'h054, 11'h060, 11'h064, 11'h040, 11'h044,
                                 11'h05C, 11'h068, 11'h06C, 11'h0C8, 11'h124, 11'h128,
                                 11'h130, 11'h13C, 11'h140};
        logic [31:0] m [15] = '{32'h00FF_FFFC, 32'h00FF_FFFC, 32'h01FF_FFFC, 32'h01FF_FFFC,
                               32'h01FF_FFFF, 32'h00FF_FF7F, 32'h3FFF_FFFF, 32'h07FF_07FF,
                               32'h03FF_03FF, 32'h03FF_33FF, 32'h00FF_FFE0, 32'h00FF_FFE0,
                               32'h00FF_FFE0, 32'h000F_003F, 32'h0013_3333};
        string tg [15] = '{"R7 disp0", "R7 disp1", "R7 rnd0", "R7 rnd1", "R8 border",
                          "R8 mode", "R8 size", "R9 hclip", "R9 vclip", "R9 hirq",
                          "R10 tile base", "R10 list base", "R10 list end",
                          "R10 tile size", "R10 tile cfg"};
        logic [31:0] v;
        for (int i = 0; i < 15; i++) begin
            wr(a[i], 32'hFFFF_FFFF);
            rd(a[i], v); check(tg[i], v, m[i]);
            wr(a[i], 32'h5A5A_A5A5);
            rd(a[i], v); check(tg[i], v, 32'h5A5A_A5A5 & m[i]);
        end
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(11'h000, 32'hFFFF_FFFF);
        wr(11'h004, 32'hFFFF_FFFF);
        wr(11'h0C4, 32'hFFFF_FFFF);
        wr(11'h134, 32'hFFFF_FFFF);
        wr(11'h138, 32'hFFFF_FFFF);
        rd(11'h000, v); check("R2 id unchanged", v, EXP_ID);
        rd(11'h004, v); check("R2 version unchanged", v, EXP_VER);
        rd(11'h0C4, v); check("R2 gun position", v, 32'h0);
        rd(11'h134, v); check("R2 list position", v, 32'h0);
        rd(11'h138, v); check("R2 polygon position", v, 32'h0);
    endtask

    task automatic t_holes();
        logic [AW-1:0] h [4] = '{11'h01C, 11'h024, 11'h028, 11'h058};
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            wr(h[i], 32'hCAFE_F00D);
            pulses("R3 hole no pulse", 3'b000);
            rd(h[i], v); check("R3 hole reads zero", v, 32'h0);
        end
    endtask

    task automatic t_render_go();
        logic [31:0] v;
        wr(11'h014, 32'hFFFF_FFFE);
        pulses("R4 near-miss value", 3'b000);
        wr(11'h014, 32'hFFFF_FFFF);
        pulses("R4 magic value", 3'b100);
        @(negedge clk);
        pulses("R4 pulse width", 3'b000);
        rd(11'h014, v); check("R4 register reads zero", v, 32'h0);
    endtask

    task automatic t_ta_reset();
        logic [31:0] v;
        wr(11'h144, 32'h7FFF_FFFF);
        pulses("R5 bit31 clear", 3'b000);
        wr(11'h144, 32'h8000_0000);
        pulses("R5 bit31 set", 3'b010);
        @(negedge clk);
        pulses("R5 pulse width", 3'b000);
        rd(11'h144, v); check("R5 register reads zero", v, 32'h0);
    endtask

    task automatic t_frame();
        logic [31:0] v;
        wr(11'h050, 32'h1234_5677);
        pulses("R6 primary write", 3'b001);
        rd(11'h050, v); check("R6 primary stored", v, 32'h0034_5674);
        wr(11'h054, 32'h1234_5677);
        pulses("R6 secondary write", 3'b000);
    endtask

    task automatic t_default_and_outside();
        logic [31:0] v;
        wr(11'h0C0, 32'hFFFF_FFFF);
        wr(11'h100, 32'h8765_4321);
        rd(11'h0C0, v); check("R11 plain word", v, 32'hFFFF_FFFF);
        rd(11'h100, v); check("R11 plain word 2", v, 32'h8765_4321);
        wr(11'h600, 32'hFFFF_FFFF);
        wr(11'h7FC, 32'hFFFF_FFFF);
        rd(11'h600, v); check("R11 outside first", v, 32'h0);
        rd(11'h7FC, v); check("R11 outside last", v, 32'h0);
        rd(11'h5FC, v); check("R11 table end intact", v, 32'h1234_5678);
    endtask

    task automatic t_low_bits();
        logic [31:0] v;
        wr(11'h102, 32'hA1B2_C3D4);
        rd(11'h100, v); check("R12 write ignores addr[1:0]", v, 32'hA1B2_C3D4);
        rd(11'h103, v); check("R12 read ignores addr[1:0]", v, 32'hA1B2_C3D4);
        rd(11'h052, v); check("R12 read display via offset", v, 32'h0034_5674);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_table();
        t_masks();
        t_readonly();
        t_holes();
        t_render_go();
        t_ta_reset();
        t_frame();
        t_default_and_outside();
        t_low_bits();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule